// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator with Commit Tracking

This block produces two independent pulse-width modulated outputs. A host programs them through a plain register bus made of an address, write data, a write strobe and combinational read data. Each channel has a clock divider, a period length and a high-time value. Software can invert the output, choose whether new settings wait for the end of the running period, and choose whether disabling cuts the waveform at once or lets the current period finish.

Every write to a channel register raises a flag in a shared status word. That flag drops once the new value has reached the waveform logic. Software polls this flag before it takes its next step, so it never has to guess how long an update takes. The address map holds four channel windows, but only the first two are built. The other two windows, and any address outside the map, read as zero and accept no writes.

Top module: `pwm_duo`

## Requirements
- R1: Channel c occupies bytes c*0x10 to c*0x10+0xF. Within that window the layout is: +0x0 control, +0x4 divider (10 bits), +0x8 period (12 bits), +0xC high-time (12 bits). A read returns the last written value masked to its field width. Control reads back its bits 3:0.
- R2: The status word sits at 0x40. Bit 8c+0 flags a pending control update for channel c, 8c+1 the divider, 8c+2 the period and 8c+3 the high-time. The bit reads 1 from the clock edge that takes the write.
- R3: Control commits on the edge after its write. A divider, period or high-time write commits on the edge after its write when autoload (control bit 2) is clear or the channel is not running. Its status bit drops at that edge.
- R4: When autoload is set and the channel is running, divider, period and high-time writes stay pending. The old values keep shaping the output until the period boundary, where the new values take effect and the status bits drop.
- R5: Each tick lasts divider+1 clocks, and a period is period+1 ticks. While running, the output is high during the first min(high-time, period+1) ticks of each period. The first period begins two edges after the write that sets enable (control bit 0).
- R6: When invert (control bit 1) is set, the output is the complement of the R5 waveform. The idle level is low when not inverted and high when inverted.
- R7: Clearing enable with stop-now (control bit 3) set puts the output at its idle level from the second edge after that control write.
- R8: Clearing enable with stop-now clear lets the current period run to its end before the output goes idle.
- R9: Control bit 4 forces the staged divider to commit, and bit 5 forces the staged period and high-time to commit, together with the control commit even under autoload. Both bits read back as 0.
- R10: Channel windows 2 and 3, and every other unmapped address, read zero and ignore writes. Writes to the status word change nothing.
- R11: Synchronous reset clears all registers and status bits and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 2 | Modulated output, one bit per channel |

## Verification
The bench measures high time over whole periods for several divider, period, high-time and invert settings. These include a high-time of zero, a high-time equal to or above the period length, and a one-tick period. Miscounting the period length or the compare would show up there as a wrong high count.

It counts how many cycles the output stays active after each kind of disable. A design that mixed up the stop-now and graceful paths would stop after two cycles where it should run to eight, or the reverse. It also polls a status bit under autoload. Committing early would show both a short pending count and the new high time in the first period.

It checks that the forced-load control bits clear pending period and high-time at once under autoload. It checks that channel 1's flags land eight bits above channel 0's, and that the unmapped channel windows stay silent.

// File: rtl/pwm_duo_pkg.sv
package pwm_duo_pkg;

    // Address layout: one window per channel, status word after all windows
    localparam int SLOT_SHIFT  = 4;
    localparam int STAT_STRIDE = 8;
    localparam int REGS_PER_CH = 4;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PSC  = 2'd1,
        SEL_PER  = 2'd2,
        SEL_DUTY = 2'd3
    } reg_sel_e;

    // Control word, bit 0 is enable
    typedef struct packed {
        logic ld_per;
        logic ld_psc;
        logic stop_now;
        logic autoload;
        logic invert;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Pending flags, bit order matches the status word nibble
    typedef struct packed {
        logic duty;
        logic per;
        logic psc;
        logic ctrl;
    } pend_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pwm_duo_cfg.sv
module pwm_duo_cfg
    import pwm_duo_pkg::*;
#(
    parameter int PSC_W   = 10,
    parameter int PER_W   = 12,
    parameter int FIELD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [FIELD_W-1:0] data_i,
    input  logic              running_i,
    input  logic              boundary_i,
    output logic              en_o,
    output logic              inv_o,
    output logic              stop_o,
    output logic [PSC_W-1:0]  psc_o,
    output logic [PER_W-1:0]  per_o,
    output logic [PER_W-1:0]  duty_o,
    output logic [3:0]        rb_ctrl_o,
    output logic [PSC_W-1:0]  rb_psc_o,
    output logic [PER_W-1:0]  rb_per_o,
    output logic [PER_W-1:0]  rb_duty_o,
    output pend_t             pend_o
);

    ctrl_t             stg_ctrl_q;
    logic [PSC_W-1:0]  stg_psc_q, act_psc_q;
    logic [PER_W-1:0]  stg_per_q, act_per_q;
    logic [PER_W-1:0]  stg_duty_q, act_duty_q;
    logic              act_en_q, act_inv_q, act_stop_q, act_auto_q;
    pend_t             pend_q;

    logic  wr_ctrl, wr_psc, wr_per, wr_duty;
    ctrl_t wr_ctrl_val;
    logic  ctrl_take, force_psc, force_pd, free_take;
    logic  psc_take, per_take, duty_take;

    assign wr_ctrl     = wr_i && (sel_i == SEL_CTRL);
    assign wr_psc      = wr_i && (sel_i == SEL_PSC);
    assign wr_per      = wr_i && (sel_i == SEL_PER);
    assign wr_duty     = wr_i && (sel_i == SEL_DUTY);
    assign wr_ctrl_val = ctrl_t'(data_i[CTRL_W-1:0]);

    // Control always lands one edge after its write; its load bits force
    // staged values through alongside it.
    assign ctrl_take = pend_q.ctrl;
    assign force_psc = ctrl_take && stg_ctrl_q.ld_psc;
    assign force_pd  = ctrl_take && stg_ctrl_q.ld_per;
    assign free_take = !act_auto_q || !running_i || boundary_i;
    assign psc_take  = pend_q.psc  && (free_take || force_psc);
    assign per_take  = pend_q.per  && (free_take || force_pd);
    assign duty_take = pend_q.duty && (free_take || force_pd);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_ctrl_q <= '0;
            stg_psc_q  <= '0;
            stg_per_q  <= '0;
            stg_duty_q <= '0;
            act_psc_q  <= '0;
            act_per_q  <= '0;
            act_duty_q <= '0;
            act_en_q   <= 1'b0;
            act_inv_q  <= 1'b0;
            act_stop_q <= 1'b0;
            act_auto_q <= 1'b0;
            pend_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                stg_ctrl_q <= wr_ctrl_val;
            end else if (ctrl_take) begin
                stg_ctrl_q.ld_psc <= 1'b0;
                stg_ctrl_q.ld_per <= 1'b0;
            end
            if (wr_psc)  stg_psc_q  <= data_i[PSC_W-1:0];
            if (wr_per)  stg_per_q  <= data_i[PER_W-1:0];
            if (wr_duty) stg_duty_q <= data_i[PER_W-1:0];

            if (ctrl_take) begin
                act_en_q   <= stg_ctrl_q.enable;
                act_inv_q  <= stg_ctrl_q.invert;
                act_stop_q <= stg_ctrl_q.stop_now;
                act_auto_q <= stg_ctrl_q.autoload;
            end
            if (psc_take)  act_psc_q  <= stg_psc_q;
            if (per_take)  act_per_q  <= stg_per_q;
            if (duty_take) act_duty_q <= stg_duty_q;

            pend_q.ctrl <= wr_ctrl;
            pend_q.psc  <= wr_psc  || (pend_q.psc  && !psc_take);
            pend_q.per  <= wr_per  || (pend_q.per  && !per_take);
            pend_q.duty <= wr_duty || (pend_q.duty && !duty_take);
        end
    end

    assign en_o      = act_en_q;
    assign inv_o     = act_inv_q;
    assign stop_o    = act_stop_q;
    assign psc_o     = act_psc_q;
    assign per_o     = act_per_q;
    assign duty_o    = act_duty_q;
    assign rb_ctrl_o = {stg_ctrl_q.stop_now, stg_ctrl_q.autoload,
                        stg_ctrl_q.invert, stg_ctrl_q.enable};
    assign rb_psc_o  = stg_psc_q;
    assign rb_per_o  = stg_per_q;
    assign rb_duty_o = stg_duty_q;
    assign pend_o    = pend_q;

    // R2: a write raises its pending flag at the taking edge
    p_write_marks_r2: assert property (@(posedge clk) disable iff (rst)
        wr_psc |=> pend_q.psc);
    p_write_marks_duty_r2: assert property (@(posedge clk) disable iff (rst)
        wr_duty |=> pend_q.duty);

    // R3: without autoload a pending period drops on the next edge
    p_quick_take_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_q.per && !act_auto_q && !wr_per) |=> !pend_q.per);

    // R4: under autoload the active high-time holds until the boundary
    p_hold_shadow_r4: assert property (@(posedge clk) disable iff (rst)
        (running_i && act_auto_q && !boundary_i && !force_pd) |=> $stable(duty_o));

    // R9: the period load bit clears period and high-time flags with control
    p_load_force_r9: assert property (@(posedge clk) disable iff (rst)
        (pend_q.ctrl && stg_ctrl_q.ld_per && !wr_per && !wr_duty)
            |=> (!pend_q.per && !pend_q.duty));

endmodule

// File: rtl/pwm_duo_gen.sv
module pwm_duo_gen #(
    parameter int PSC_W = 10,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             inv_i,
    input  logic             stop_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic [PER_W-1:0] per_i,
    input  logic [PER_W-1:0] duty_i,
    output logic             running_o,
    output logic             boundary_o,
    output logic             pwm_o
);

    logic             run_q;
    logic [PSC_W-1:0] psc_cnt_q;
    logic [PER_W-1:0] cnt_q;
    logic             tick, wrap;

    // Compare with >= so a value lowered by a forced load still wraps
    assign tick = run_q && (psc_cnt_q >= psc_i);
    assign wrap = tick && (cnt_q >= per_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            psc_cnt_q <= '0;
            cnt_q     <= '0;
        end else if (!run_q) begin
            psc_cnt_q <= '0;
            cnt_q     <= '0;
            run_q     <= en_i;
        end else if (!en_i && (stop_i || wrap)) begin
            run_q     <= 1'b0;
            psc_cnt_q <= '0;
            cnt_q     <= '0;
        end else if (tick) begin
            psc_cnt_q <= '0;
            cnt_q     <= wrap ? '0 : cnt_q + 1'b1;
        end else begin
            psc_cnt_q <= psc_cnt_q + 1'b1;
        end
    end

    assign running_o  = run_q;
    assign boundary_o = wrap;
    assign pwm_o      = run_q ? ((cnt_q < duty_i) ^ inv_i) : inv_i;

    // R5: a start always begins from a cleared divider and period count
    p_start_clean_r5: assert property (@(posedge clk) disable iff (rst)
        (!run_q && en_i) |=> (run_q && cnt_q == '0 && psc_cnt_q == '0));

    // R7: stop-now halts on the next edge
    p_halt_now_r7: assert property (@(posedge clk) disable iff (rst)
        (run_q && !en_i && stop_i) |=> !run_q);

    // R8: a graceful stop keeps running until the period ends
    p_finish_period_r8: assert property (@(posedge clk) disable iff (rst)
        (run_q && !en_i && !stop_i && !wrap) |=> run_q);

    // R6: once stopped the output sits at the idle level for the polarity
    p_idle_level_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(run_q) && $stable(inv_i)) |-> (pwm_o == inv_i));

endmodule

// File: rtl/pwm_duo.sv
module pwm_duo
    import pwm_duo_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int PSC_W     = 10,
    parameter int PER_W     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int FIELD_W = max3(PSC_W, PER_W, CTRL_W);
    localparam int SLOT_W  = ADDR_W - SLOT_SHIFT;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_SLOTS << SLOT_SHIFT);

    logic [SLOT_W-1:0] slot;
    logic [1:0]        sel_idx;
    reg_sel_e          sel;
    logic              unused_bus_bits;

    assign slot            = bus_addr[ADDR_W-1:SLOT_SHIFT];
    assign sel_idx         = bus_addr[3:2];
    assign sel             = reg_sel_e'(sel_idx);
    assign unused_bus_bits = ^{bus_wdata[DATA_W-1:FIELD_W], bus_addr[1:0]};

    pend_t             pend_all [NUM_CH];
    logic [DATA_W-1:0] rb_word  [NUM_CH][REGS_PER_CH];
    logic [DATA_W-1:0] status_word;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             hit, en, inv, stop, run, bnd;
        logic [PSC_W-1:0] psc, rb_psc;
        logic [PER_W-1:0] per, duty, rb_per, rb_duty;
        logic [3:0]       rb_ctrl;
        pend_t            pend;

        assign hit = (slot == SLOT_W'(c));

        pwm_duo_cfg #(
            .PSC_W  (PSC_W),
            .PER_W  (PER_W),
            .FIELD_W(FIELD_W)
        ) u_cfg (
            .clk       (clk),
            .rst       (rst),
            .wr_i      (bus_wr && hit),
            .sel_i     (sel),
            .data_i    (bus_wdata[FIELD_W-1:0]),
            .running_i (run),
            .boundary_i(bnd),
            .en_o      (en),
            .inv_o     (inv),
            .stop_o    (stop),
            .psc_o     (psc),
            .per_o     (per),
            .duty_o    (duty),
            .rb_ctrl_o (rb_ctrl),
            .rb_psc_o  (rb_psc),
            .rb_per_o  (rb_per),
            .rb_duty_o (rb_duty),
            .pend_o    (pend)
        );

        pwm_duo_gen #(
            .PSC_W(PSC_W),
            .PER_W(PER_W)
        ) u_gen (
            .clk       (clk),
            .rst       (rst),
            .en_i      (en),
            .inv_i     (inv),
            .stop_i    (stop),
            .psc_i     (psc),
            .per_i     (per),
            .duty_i    (duty),
            .running_o (run),
            .boundary_o(bnd),
            .pwm_o     (pwm_out[c])
        );

        assign pend_all[c]   = pend;
        assign rb_word[c][0] = DATA_W'(rb_ctrl);
        assign rb_word[c][1] = DATA_W'(rb_psc);
        assign rb_word[c][2] = DATA_W'(rb_per);
        assign rb_word[c][3] = DATA_W'(rb_duty);
    end

    always_comb begin
        status_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            status_word[c*STAT_STRIDE +: REGS_PER_CH] = pend_all[c];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STATUS_ADDR) begin
            bus_rdata = status_word;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (slot == SLOT_W'(c)) bus_rdata = rb_word[c][sel_idx];
            end
        end
    end

    // R10: addresses past the built channels, other than status, read zero
    p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (rst)
        ((slot >= SLOT_W'(NUM_CH)) && (bus_addr != STATUS_ADDR)) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_pwm_duo.sv
`timescale 1ns/1ps
module sim_pwm_duo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic [1:0]  pwm;

    always #2.5 clk = ~clk;

    pwm_duo u0 (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (addr),
        .bus_wdata(wdata),
        .bus_wr   (wr),
        .bus_rdata(rdata),
        .pwm_out  (pwm)
    );

    localparam logic [7:0] STAT = 8'h40;

    typedef struct packed {
        int   ps;
        int   per;
        int   duty;
        logic inv;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{0, 4, 2, 1'b0},
        '{1, 3, 1, 1'b0},
        '{2, 5, 6, 1'b0},
        '{0, 7, 0, 1'b0},
        '{0, 3, 9, 1'b1},
        '{3, 2, 1, 1'b1},
        '{0, 0, 1, 1'b0}
    };

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n, hi;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        for (int a = 0; a < 8; a++) begin
            rd_reg(8'(a * 4), d);
            check("R11", d, 0, "register after reset");
        end
        rd_reg(STAT, d);
        check("R11", d, 0, "status after reset");
        check("R11", 32'(pwm), 0, "outputs after reset");

        // R2 / R3: pending flag positions and fast commit
        wr_reg(8'h04, 32'd5);
        rd_reg(STAT, d);
        check("R2", d, 32'h2, "ch0 divider flag");
        @(negedge clk);
        rd_reg(STAT, d);
        check("R3", d, 0, "ch0 divider flag dropped");
        rd_reg(8'h04, d);
        check("R1", d, 5, "ch0 divider readback");
        wr_reg(8'h1C, 32'd3);
        rd_reg(STAT, d);
        check("R2", d, 32'h800, "ch1 high-time flag at bit 11");
        @(negedge clk);
        rd_reg(STAT, d);
        check("R3", d, 0, "ch1 high-time flag dropped");

        // R1: field masking
        wr_reg(8'h04, 32'hFFFF_FFFF);
        rd_reg(8'h04, d);
        check("R1", d, 32'h3FF, "divider masked to 10 bits");
        wr_reg(8'h08, 32'hFFFF_FFFF);
        rd_reg(8'h08, d);
        check("R1", d, 32'hFFF, "period masked to 12 bits");
        wr_reg(8'h00, 32'hFE);
        rd_reg(8'h00, d);
        check("R9", d, 32'hE, "control load bits read zero");
        @(negedge clk); @(negedge clk); #1;
        check("R6", 32'(pwm[0]), 1, "inverted idle level high");

        // R10: unbuilt channel windows and status are write-proof
        wr_reg(8'h20, 32'hFF);
        wr_reg(8'h38, 32'h123);
        rd_reg(8'h20, d);
        check("R10", d, 0, "slot 2 control reads zero");
        rd_reg(8'h38, d);
        check("R10", d, 0, "slot 3 period reads zero");
        rd_reg(STAT, d);
        check("R10", d, 0, "no flag from unbuilt slot write");
        wr_reg(STAT, 32'hFFFF_FFFF);
        rd_reg(STAT, d);
        check("R10", d, 0, "status ignores writes");

        // R5 / R6 / R7: table of waveform settings
        foreach (VECS[i]) begin
            automatic vec_t v = VECS[i];
            automatic int ch = i % 2;
            automatic logic [7:0] base = 8'(ch * 16);
            automatic int win = 2 * (v.ps + 1) * (v.per + 1);
            automatic int lim = (v.duty < v.per + 1) ? v.duty : v.per + 1;
            automatic int exp_hi = 2 * (v.ps + 1) * lim;
            if (v.inv) exp_hi = win - exp_hi;
            wr_reg(base, 32'h8);
            wr_reg(base + 8'h4, 32'(v.ps));
            wr_reg(base + 8'h8, 32'(v.per));
            wr_reg(base + 8'hC, 32'(v.duty));
            rd_reg(base + 8'h8, d);
            check("R1", d, 32'(v.per), "period readback");
            wr_reg(base, 32'h1 | (32'(v.inv) << 1));
            @(negedge clk); @(negedge clk);
            hi = 0;
            for (int j = 0; j < win; j++) begin
                #1;
                if (pwm[ch]) hi++;
                @(negedge clk);
            end
            check(v.inv ? "R6" : "R5", 32'(hi), 32'(exp_hi), "high cycles over two periods");
            wr_reg(base, 32'h8 | (32'(v.inv) << 1));
            @(negedge clk); @(negedge clk); #1;
            check("R7", 32'(pwm[ch]), 32'(v.inv), "idle level after stop-now");
        end

        // R8: graceful stop runs the period to its end
        wr_reg(8'h10, 32'h8);
        wr_reg(8'h14, 32'd1);
        wr_reg(8'h18, 32'd3);
        wr_reg(8'h1C, 32'd15);
        wr_reg(8'h10, 32'h1);
        wr_reg(8'h10, 32'h0);
        n = 0; #1;
        while (pwm[1] && n < 50) begin n++; @(negedge clk); #1; end
        check("R8", 32'(n), 8, "cycles active after graceful stop");

        // R7: stop-now cuts after two edges
        wr_reg(8'h10, 32'h1);
        wr_reg(8'h10, 32'h8);
        n = 0; #1;
        while (pwm[1] && n < 50) begin n++; @(negedge clk); #1; end
        check("R7", 32'(n), 2, "cycles active after stop-now");

        // R4: autoload holds the new high-time to the boundary
        wr_reg(8'h00, 32'h8);
        wr_reg(8'h04, 32'd0);
        wr_reg(8'h08, 32'd9);
        wr_reg(8'h0C, 32'd3);
        wr_reg(8'h00, 32'h5);
        wr_reg(8'h0C, 32'd7);
        addr = STAT; n = 0; hi = 0; #1;
        while (rdata[3] && n < 40) begin
            if (pwm[0]) hi++;
            n++;
            @(negedge clk); #1;
        end
        check("R4", 32'(n), 10, "cycles high-time stayed pending");
        check("R4", 32'(hi), 3, "old high-time used before boundary");
        hi = 0;
        for (int j = 0; j < 10; j++) begin
            if (pwm[0]) hi++;
            @(negedge clk); #1;
        end
        check("R4", 32'(hi), 7, "new high-time after boundary");

        // R9: forced load of period and high-time under autoload
        wr_reg(8'h00, 32'h8);
        wr_reg(8'h08, 32'd100);
        wr_reg(8'h0C, 32'd200);
        wr_reg(8'h00, 32'h5);
        wr_reg(8'h08, 32'd5);
        wr_reg(8'h0C, 32'd0);
        rd_reg(STAT, d);
        check("R4", d, 32'hC, "period and high-time held pending");
        wr_reg(8'h00, 32'h25);
        rd_reg(STAT, d);
        check("R9", d, 32'hD, "flags with forced load queued");
        @(negedge clk);
        rd_reg(STAT, d);
        check("R9", d, 0, "forced load cleared flags");
        check("R9", 32'(pwm[0]), 0, "zero high-time in effect");
        rd_reg(8'h00, d);
        check("R9", d, 32'h5, "load bit reads zero");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule